// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block computes the sixteen syndromes of a 255-symbol Reed-Solomon codeword over GF(2^8). It sits at the front of a decoder and takes one 8-bit received symbol per clock whenever a valid strobe is high. Each syndrome lane folds the incoming symbol into its running value with a Horner step: the lane multiplies its value by a fixed power of the primitive element and then adds the new symbol. The multiply is by a constant, so each lane is a small XOR network and takes one cycle per symbol.

The first symbol of a codeword is the coefficient of the highest power, x^254. After the 255th valid symbol, the block copies all sixteen lane results into an output bank and raises a one-cycle completion pulse. A flag beside the bank reports whether every syndrome is zero, which means the received word is a valid codeword. Idle cycles may fall anywhere inside a codeword. The bank keeps its contents until the next codeword completes, so the key-equation stage downstream can read them at any time.

Top module: `rs_syndrome_calc`

## Requirements
- R1: The field is GF(2^8) with reduction polynomial 0x11D and primitive element alpha = 0x02. Syndrome S_i is the received polynomial evaluated at alpha^i, for i = 0 to 15. The first symbol received is the coefficient of x^254 and the last is the coefficient of x^0. S_i is presented on syn_flat bits [8i+7:8i].
- R2: A symbol is absorbed only on a clock edge where sym_valid is 1. Cycles with sym_valid at 0 change neither the codeword progress nor any output, whatever the value on sym_data.
- R3: Each codeword starts from a clean state. The first valid symbol after reset, or after a completed codeword, is loaded into every lane directly, so no value from an earlier codeword carries over.
- R4: syn_done is 1 for exactly one cycle. That cycle is the one that immediately follows the clock edge that absorbs the 255th valid symbol. syn_done is 0 at all other times.
- R5: syn_flat and syn_all_zero change only together with a syn_done pulse, and keep their values until the next one.
- R6: syn_all_zero is 1 exactly when all sixteen syndromes in the bank are 0x00.
- R7: While rst is 1 and after it is released, syn_done is 0, syn_all_zero is 0 and syn_flat is all zeros. The next valid symbol is taken as the first symbol of a new codeword.
- R8: S0 equals the XOR of all 255 received symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Received symbol on sym_data is valid this cycle |
| sym_data | input | 8 | Received symbol, highest-degree coefficient first |
| syn_done | output | 1 | One-cycle pulse when a new syndrome set is in the bank |
| syn_all_zero | output | 1 | All sixteen banked syndromes are zero |
| syn_flat | output | 128 | Banked syndromes, S_i at bits [8i+7:8i] |

## Verification
If the symbol counter drifts, the completion pulse arrives one or more symbols early or late. That error shows at the first completion, at the latest 255 valid symbols after the fault. A lane that keeps a stale value, or that multiplies by the wrong power, corrupts its own byte of syn_flat. The all-zero flag then also goes wrong for a valid codeword, visible in the cycle after the last symbol. Because the stimulus mixes real codewords, single errors, burst errors and non-codewords, with and without idle gaps, a fault in any one lane or in the gap handling reaches the ports within one codeword.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    localparam int SYM_W = 8;
    localparam int N_SYM = 255;
    localparam int N_SYN = 16;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;
    localparam int CNT_W = $clog2(N_SYM);

    typedef logic [SYM_W-1:0] sym_t;
    typedef sym_t [N_SYN-1:0] syn_vec_t;

    typedef struct packed {
        logic first;
        logic last;
    } pos_flags_t;

    // multiply by alpha once: shift and conditionally reduce
    function automatic sym_t gf_xtime(sym_t x);
        sym_t r;
        r = {x[SYM_W-2:0], 1'b0};
        if (x[SYM_W-1]) r = r ^ FIELD_POLY[SYM_W-1:0];
        return r;
    endfunction

    // multiply by alpha^k with k a constant: unrolls to pure XOR logic
    function automatic sym_t gf_mul_alpha_pow(sym_t x, int k);
        sym_t r;
        r = x;
        for (int j = 0; j < k; j++) r = gf_xtime(r);
        return r;
    endfunction

endpackage

// File: rtl/rs_syn_counter.sv
module rs_syn_counter
    import rs_syn_pkg::*;
#(
    parameter int NUM_SYM = N_SYM
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    output pos_flags_t flags
);
    localparam int CW = $clog2(NUM_SYM);
    localparam logic [CW-1:0] LAST_IDX = CW'(NUM_SYM - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (valid) begin
            if (cnt == LAST_IDX) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        flags.first = (cnt == '0);
        flags.last  = (cnt == LAST_IDX);
    end

endmodule

// File: rtl/rs_syn_lane.sv
module rs_syn_lane
    import rs_syn_pkg::*;
#(
    parameter int POW = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic first,
    input  sym_t data,
    output sym_t acc_nxt
);
    sym_t acc;

    always_comb begin
        if (first) acc_nxt = data;
        else       acc_nxt = gf_mul_alpha_pow(acc, POW) ^ data;
    end

    always_ff @(posedge clk) begin
        if (rst)        acc <= '0;
        else if (valid) acc <= acc_nxt;
    end

endmodule

// File: rtl/rs_syn_bank.sv
module rs_syn_bank
    import rs_syn_pkg::*;
#(
    parameter int NUM_SYN = N_SYN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  sym_t [NUM_SYN-1:0]     syn_in,
    output sym_t [NUM_SYN-1:0]     syn_q,
    output logic                   done,
    output logic                   all_zero
);
    logic in_zero;

    always_comb begin
        in_zero = 1'b1;
        for (int i = 0; i < NUM_SYN; i++)
            if (syn_in[i] != '0) in_zero = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_q    <= '0;
            done     <= 1'b0;
            all_zero <= 1'b0;
        end else begin
            done <= load;
            if (load) begin
                syn_q    <= syn_in;
                all_zero <= in_zero;
            end
        end
    end

endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
    import rs_syn_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sym_valid,
    input  logic [SYM_W-1:0]       sym_data,
    output logic                   syn_done,
    output logic                   syn_all_zero,
    output logic [N_SYN*SYM_W-1:0] syn_flat
);
    pos_flags_t flags;
    syn_vec_t   lane_nxt;
    syn_vec_t   bank_q;

    rs_syn_counter #(.NUM_SYM(N_SYM)) i_cnt (
        .clk   (clk),
        .rst   (rst),
        .valid (sym_valid),
        .flags (flags)
    );

    for (genvar g = 0; g < N_SYN; g++) begin : g_lane
        rs_syn_lane #(.POW(g)) i_lane (
            .clk     (clk),
            .rst     (rst),
            .valid   (sym_valid),
            .first   (flags.first),
            .data    (sym_data),
            .acc_nxt (lane_nxt[g])
        );
    end

    rs_syn_bank #(.NUM_SYN(N_SYN)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .load     (sym_valid & flags.last),
        .syn_in   (lane_nxt),
        .syn_q    (bank_q),
        .done     (syn_done),
        .all_zero (syn_all_zero)
    );

    assign syn_flat = bank_q;

endmodule

// File: rtl/rs_syndrome_chk.sv
module rs_syndrome_chk
    import rs_syn_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   sym_valid,
    input logic [SYM_W-1:0]       sym_data,
    input logic                   syn_done,
    input logic                   syn_all_zero,
    input logic [N_SYN*SYM_W-1:0] syn_flat
);
    int   seen;
    sym_t par_run;
    sym_t par_last;
    logic at_last;

    assign at_last = sym_valid && (seen == N_SYM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= 0;
            par_run  <= '0;
            par_last <= '0;
        end else if (sym_valid) begin
            seen    <= (seen == N_SYM - 1) ? 0 : seen + 1;
            par_run <= (seen == 0) ? sym_data : (par_run ^ sym_data);
            if (seen == N_SYM - 1) par_last <= par_run ^ sym_data;
        end
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        at_last |=> syn_done); // R4
    AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        !at_last |=> !syn_done); // R4
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !syn_done |-> $stable(syn_flat) && $stable(syn_all_zero)); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        syn_done |-> (syn_all_zero == (syn_flat == '0))); // R6
    AST_S0_PARITY: assert property (@(posedge clk) disable iff (rst)
        syn_done |-> (syn_flat[SYM_W-1:0] == par_last)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !syn_done && !syn_all_zero && (syn_flat == '0)); // R7

endmodule

bind rs_syndrome_calc rs_syndrome_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .sym_valid    (sym_valid),
    .sym_data     (sym_data),
    .syn_done     (syn_done),
    .syn_all_zero (syn_all_zero),
    .syn_flat     (syn_flat)
);

// File: tb/test_rs_syndrome_calc.sv
module test_rs_syndrome_calc;

    localparam int NS = 255;
    localparam int NQ = 16;

    typedef struct packed {
        logic [2:0] kind;   // 0 zeros,1 codeword,2 cw+single err,3 cw+burst,4 ramp,5 all FF
        logic [7:0] seed;
        logic [7:0] pos;    // exponent of the corrupted coefficient
        logic [7:0] val;
        logic       gap;    // insert idle cycles inside the word
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{3'd0, 8'h00, 8'd0,   8'h00, 1'b0},
        '{3'd1, 8'h13, 8'd0,   8'h00, 1'b0},
        '{3'd2, 8'h13, 8'd0,   8'h5A, 1'b0},
        '{3'd2, 8'h77, 8'd254, 8'h01, 1'b1},
        '{3'd3, 8'h00, 8'd0,   8'h00, 1'b0},
        '{3'd4, 8'h05, 8'd0,   8'h00, 1'b1},
        '{3'd1, 8'hC4, 8'd0,   8'h00, 1'b1},
        '{3'd5, 8'h00, 8'd0,   8'h00, 1'b0},
        '{3'd2, 8'h99, 8'd100, 8'hFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        sym_valid;
    logic [7:0]  sym_data;
    logic        syn_done;
    logic        syn_all_zero;
    logic [127:0] syn_flat;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] cw [0:NS-1];
    logic [7:0] gen [0:NQ];
    logic [7:0] exp_s [0:NQ-1];

    always #5 clk = ~clk;

    rs_syndrome_calc i_rs_syndrome_calc (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_data(sym_data),
        .syn_done(syn_done), .syn_all_zero(syn_all_zero), .syn_flat(syn_flat)
    );

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11D << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] apow(int k);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < k; i++) r = gmul(r, 8'h02);
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // generator polynomial, highest-degree coefficient first, roots alpha^0..alpha^15
    task automatic build_gen();
        logic [7:0] t [0:NQ];
        for (int j = 0; j <= NQ; j++) gen[j] = 8'h00;
        gen[0] = 8'h01;
        for (int r = 0; r < NQ; r++) begin
            for (int j = 0; j <= NQ; j++) t[j] = gen[j];
            for (int j = 1; j <= r + 1; j++) gen[j] = t[j] ^ gmul(apow(r), t[j-1]);
        end
    endtask

    task automatic encode(logic [7:0] seed);
        logic [7:0] w [0:NS-1];
        logic [7:0] c;
        for (int k = 0; k < NS; k++) w[k] = (k < NS - NQ) ? 8'(seed + 8'(7 * k) ^ 8'(k >> 3)) : 8'h00;
        for (int k = 0; k < NS; k++) cw[k] = w[k];
        for (int k = 0; k < NS - NQ; k++) begin
            c = w[k];
            for (int j = 1; j <= NQ; j++) w[k+j] = w[k+j] ^ gmul(c, gen[j]);
        end
        for (int k = NS - NQ; k < NS; k++) cw[k] = w[k];
    endtask

    task automatic build_word(vec_t v);
        case (v.kind)
            3'd0: for (int k = 0; k < NS; k++) cw[k] = 8'h00;
            3'd1: encode(v.seed);
            3'd2: begin encode(v.seed); cw[NS-1-int'(v.pos)] ^= v.val; end
            3'd3: begin encode(v.seed); for (int p = 105; p <= 112; p++) cw[NS-1-p] ^= 8'h01; end
            3'd4: for (int k = 0; k < NS; k++) cw[k] = 8'(k) + v.seed;
            default: for (int k = 0; k < NS; k++) cw[k] = 8'hFF;
        endcase
    endtask

    task automatic golden();
        for (int i = 0; i < NQ; i++) begin
            logic [7:0] a = apow(i);
            logic [7:0] acc = 8'h00;
            for (int k = 0; k < NS; k++) acc = gmul(acc, a) ^ cw[k];
            exp_s[i] = acc;
        end
    endtask

    // sends cw; checks done timing, bank contents and zero flag
    task automatic send_and_check(bit gap, bit not_first);
        int early = 0;
        bit az;
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            if (syn_done) early++;
            sym_valid = 1'b1;
            sym_data  = cw[k];
            if (gap && (k % 3 == 1)) begin
                @(negedge clk);
                if (syn_done) early++;
                sym_valid = 1'b0;
                sym_data  = 8'hA5 ^ 8'(k);   // garbage while idle (R2)
            end
        end
        @(negedge clk);
        sym_valid = 1'b0;
        sym_data  = 8'h3C;
        check("R4 no done before last symbol", 128'(early), 128'd0);
        check("R4 done after last symbol", 128'(syn_done), 128'd1);
        az = 1'b1;
        for (int i = 0; i < NQ; i++) begin
            if (exp_s[i] != 8'h00) az = 1'b0;
            if (i == 0)
                check("R8 S0 parity", 128'(syn_flat[7:0]), 128'(exp_s[0]));
            else if (gap)
                check("R2 syndrome with idle gaps", 128'(syn_flat[8*i +: 8]), 128'(exp_s[i]));
            else if (not_first)
                check("R3 syndrome of following word", 128'(syn_flat[8*i +: 8]), 128'(exp_s[i]));
            else
                check("R1 syndrome value", 128'(syn_flat[8*i +: 8]), 128'(exp_s[i]));
        end
        check("R6 all-zero flag", 128'(syn_all_zero), 128'(az));
        @(negedge clk);
        check("R4 done lasts one cycle", 128'(syn_done), 128'd0);
    endtask

    initial begin
        logic [127:0] held;
        logic         held_z;
        rst = 1'b1; sym_valid = 1'b0; sym_data = 8'h00;
        build_gen();
        repeat (3) @(negedge clk);
        check("R7 reset done", 128'(syn_done), 128'd0);
        check("R7 reset all_zero", 128'(syn_all_zero), 128'd0);
        check("R7 reset bank", syn_flat, 128'd0);
        rst = 1'b0;

        for (int n = 0; n < 9; n++) begin
            build_word(VEC[n]);
            golden();
            send_and_check(VEC[n].gap, n > 0);
        end

        // hold: idle garbage changes nothing (R2, R5)
        held = syn_flat; held_z = syn_all_zero;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            sym_valid = 1'b0; sym_data = 8'(c * 37);
        end
        @(negedge clk);
        check("R5 bank held while idle", syn_flat, held);
        check("R5 flag held while idle", 128'(syn_all_zero), 128'(held_z));
        check("R2 no done while idle", 128'(syn_done), 128'd0);

        // partial word, then reset: restarts at the first symbol (R7, R3)
        for (int c = 0; c < 100; c++) begin
            @(negedge clk); sym_valid = 1'b1; sym_data = 8'hEE;
        end
        @(negedge clk); sym_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        check("R7 bank cleared by reset", syn_flat, 128'd0);
        build_word(VEC[1]);
        golden();
        send_and_check(1'b0, 1'b1);
        check("R7 codeword after reset all_zero", 128'(syn_all_zero), 128'd1);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule